// File: doc/BRIEF.md
# ECC syndrome checker and corrector

This block checks a page of flash data one chunk at a time. For each chunk it receives two error-correcting codes. One is the code that was stored with the data. The other is the code recomputed while the data was read back. The block XORs the two codes to form a syndrome. It counts the set bits in that syndrome and classifies the chunk from the count alone.

When a chunk holds a single correctable bit error, the block issues a flip request with a page-absolute byte address and a bit index. The data buffer sits outside the block and applies the flip. At the end of the page the block pulses `done` and presents one status code for the whole page. The check stops at the first chunk that cannot be corrected.

A run begins with a one-cycle `start`, which carries the chunk count and the code mode. There are two code modes:
- **Chunk mode:** each 256-byte chunk has a 3-byte code.
- **Page mode:** the whole page has a single 4-byte code.

Codes are presented one per cycle with `code_valid`, and back-to-back presentation is allowed.

Top module: `ecc_syndrome_checker`

## Requirements
- R1: The syndrome is `stored_code ^ fresh_code`. Code byte k occupies bits [8k+7:8k]. A chunk whose syndrome is zero is clean and issues no flip request. A run made only of clean chunks ends with status 0.
- R2: In chunk mode (`page_mode`=0), only code bytes 0 to 2 count, and byte 3 is ignored. A syndrome with exactly 11 set bits is a correctable error, which raises `flip_valid` for one cycle. `flip_bit` is syndrome bits [2:0]. `flip_byte` is chunk_number×256 plus a relative byte index. The relative byte index takes syndrome bits [10:8] as its upper 3 bits and syndrome bits [7:3] as its lower 5 bits.
- R3: In page mode (`page_mode`=1), all 4 code bytes count, and exactly 15 set bits is correctable. `flip_bit` is syndrome bits [3:0]. `flip_byte` takes syndrome bits [15:8] as its upper 8 bits and bits [7:4] as its lower 4 bits, with no chunk offset.
- R4: A syndrome with exactly one set bit marks a damaged stored code. The run ends at once with status 2.
- R5: Any other nonzero set-bit count is an uncorrectable multi-bit error. The run ends at once with status 3.
- R6: Status codes are 0 for clean, 1 for corrected, 2 for a damaged code and 3 for multi-bit.
  - A correction seen earlier in a run is remembered across later clean chunks, so such a run ends with status 1.
  - `status` changes only together with `done`, or to 0 on `start`.
  - `status` holds its value until the next `start`.
- R7: After an aborting chunk, codes already presented for later chunks of that run produce no flip request and no second `done`.
- R8: A code sampled at clock edge N has its flip request and, for the final or aborting chunk, its `done` visible after edge N+1. `done` is a one-cycle pulse.
- R9: With `chunk_count`=0, `done` follows `start` by one cycle with status 0. The block ignores `code_valid` outside a run, in the `start` cycle, and beyond `chunk_count` codes.
- R10: After reset, `flip_valid`, `done` and `status` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a new run and captures `chunk_count` and `page_mode` |
| page_mode | input | 1 | 1 selects one 4-byte code per page; 0 selects 3-byte codes per 256-byte chunk |
| chunk_count | input | CNT_W (5) | Number of codes in the run, at most MAX_CHUNKS |
| code_valid | input | 1 | A code pair is present this cycle |
| stored_code | input | 32 | Code read back from storage |
| fresh_code | input | 32 | Code recomputed from the data |
| flip_valid | output | 1 | A flip request is present this cycle |
| flip_byte | output | ADDR_W (12) | Page-absolute byte to flip |
| flip_bit | output | 4 | Bit position to flip within that byte (or 16-bit word in page mode) |
| status | output | 2 | Final page status, valid from `done` onwards |
| done | output | 1 | One-cycle pulse when the run ends |

## Verification
The vector table includes syndromes that land one bit away from the correctable count. It also includes syndromes whose set bits sit partly in code byte 3. A design that counted byte 3 in chunk mode would therefore report multi-bit where a correction is due, and a design that swapped the two counts would flip in the wrong mode.

Directed runs put a correction in a later chunk. There a missing chunk offset gives a byte address that is 256 bytes short, and a status that is not sticky reports 0 instead of 1. Other runs place further codes straight after an aborting chunk; a design that kept accepting them would raise stray flips or a second `done`. An empty run and the hold of `status` after `done` complete the set.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;
  localparam int CODE_W        = 32;
  localparam int CHUNK_CODE_W  = 24;
  localparam int CHUNK_LOG2    = 8;
  localparam int PAGE_POS_W    = 12;
  localparam int BIT_W         = 4;
  localparam int ONES_W        = 6;
  localparam int CHUNK_FIX_ONES = 11;
  localparam int PAGE_FIX_ONES  = 15;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_FIXED    = 2'd1,
    ST_CODE_BAD = 2'd2,
    ST_MULTI    = 2'd3
  } chk_status_e;

  // Set bits of the syndrome; upper code byte excluded in chunk mode.
  function automatic logic [ONES_W-1:0] count_ones(input logic [CODE_W-1:0] syn,
                                                   input logic page_mode);
    logic [ONES_W-1:0] n;
    n = '0;
    for (int i = 0; i < CODE_W; i++) begin
      if (page_mode || (i < CHUNK_CODE_W)) n = n + ONES_W'(syn[i]);
    end
    return n;
  endfunction

  function automatic logic [ONES_W-1:0] fix_target(input logic page_mode);
    return page_mode ? ONES_W'(PAGE_FIX_ONES) : ONES_W'(CHUNK_FIX_ONES);
  endfunction

  function automatic chk_status_e classify(input logic [ONES_W-1:0] ones,
                                           input logic page_mode);
    if (ones == '0)                        return ST_CLEAN;
    else if (ones == fix_target(page_mode)) return ST_FIXED;
    else if (ones == ONES_W'(1))           return ST_CODE_BAD;
    else                                   return ST_MULTI;
  endfunction

  // Relative byte index of the failing bit.
  function automatic logic [PAGE_POS_W-1:0] rel_byte(input logic [CODE_W-1:0] syn,
                                                     input logic page_mode);
    if (page_mode) return {syn[15:8], syn[7:4]};
    else           return {4'b0000, syn[10:8], syn[7:3]};
  endfunction

  function automatic logic [BIT_W-1:0] rel_bit(input logic [CODE_W-1:0] syn,
                                               input logic page_mode);
    if (page_mode) return syn[3:0];
    else           return {1'b0, syn[2:0]};
  endfunction
endpackage

// File: rtl/ecc_syn_stage.sv
module ecc_syn_stage
  import ecc_chk_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                take,
  input  logic                page_mode,
  input  logic [CODE_W-1:0]   stored_code,
  input  logic [CODE_W-1:0]   fresh_code,
  input  logic [IDX_W-1:0]    idx_in,
  output logic                s1_valid,
  output logic [CODE_W-1:0]   s1_syn,
  output logic [ONES_W-1:0]   s1_ones,
  output logic [IDX_W-1:0]    s1_idx
);
  logic [CODE_W-1:0] syn_now;
  logic [ONES_W-1:0] ones_now;

  assign syn_now  = stored_code ^ fresh_code;
  assign ones_now = count_ones(syn_now, page_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_syn   <= '0;
      s1_ones  <= '0;
      s1_idx   <= '0;
    end else begin
      s1_valid <= take && !flush;
      if (take) begin
        s1_syn  <= syn_now;
        s1_ones <= ones_now;
        s1_idx  <= idx_in;
      end
    end
  end

  // A clean registered syndrome must carry a zero count (R1)
  assert_zero_syn_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_syn == '0) |-> (s1_ones == '0));
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import ecc_chk_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 12
) (
  input  logic                page_mode,
  input  logic [CODE_W-1:0]   s1_syn,
  input  logic [ONES_W-1:0]   s1_ones,
  input  logic [IDX_W-1:0]    s1_idx,
  output chk_status_e         cls,
  output logic [ADDR_W-1:0]   pos_abs,
  output logic [BIT_W-1:0]    pos_bit
);
  logic [PAGE_POS_W-1:0] rel;
  logic [ADDR_W-1:0]     base;

  assign cls     = classify(s1_ones, page_mode);
  assign rel     = rel_byte(s1_syn, page_mode);
  assign pos_bit = rel_bit(s1_syn, page_mode);
  assign base    = ADDR_W'(s1_idx) << CHUNK_LOG2;

  always_comb begin
    if (page_mode) pos_abs = ADDR_W'(rel);
    else           pos_abs = base | ADDR_W'(rel[CHUNK_LOG2-1:0]);
  end
endmodule

// File: rtl/ecc_seq.sv
module ecc_seq
  import ecc_chk_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                page_mode,
  input  logic [CNT_W-1:0]    chunk_count,
  input  logic                code_valid,
  input  logic                s1_valid,
  input  logic [ONES_W-1:0]   s1_ones,
  input  logic [IDX_W-1:0]    s1_idx,
  input  chk_status_e         cls,
  input  logic [ADDR_W-1:0]   pos_abs,
  input  logic [BIT_W-1:0]    pos_bit,
  output logic                take,
  output logic [IDX_W-1:0]    take_idx,
  output logic                run_page,
  output logic                active,
  output logic                flip_valid,
  output logic [ADDR_W-1:0]   flip_byte,
  output logic [BIT_W-1:0]    flip_bit,
  output logic [1:0]          status,
  output logic                done
);
  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] acc_cnt;
  chk_status_e      sticky;
  chk_status_e      merged;
  logic             abort_now;
  logic             last_now;
  logic             finish_now;

  assign abort_now  = s1_valid && (cls == ST_CODE_BAD || cls == ST_MULTI);
  assign last_now   = s1_valid && ((CNT_W'(s1_idx) + CNT_W'(1)) == total);
  assign finish_now = active && !start && (abort_now || last_now);
  assign take       = active && !start && code_valid && (acc_cnt < total) && !abort_now;
  assign take_idx   = acc_cnt[IDX_W-1:0];

  always_comb begin
    if (abort_now)                        merged = cls;
    else if (s1_valid && cls == ST_FIXED) merged = ST_FIXED;
    else                                  merged = sticky;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      run_page   <= 1'b0;
      total      <= '0;
      acc_cnt    <= '0;
      sticky     <= ST_CLEAN;
      status     <= 2'd0;
      done       <= 1'b0;
      flip_valid <= 1'b0;
      flip_byte  <= '0;
      flip_bit   <= '0;
    end else if (start) begin
      active     <= (chunk_count != '0);
      run_page   <= page_mode;
      total      <= chunk_count;
      acc_cnt    <= '0;
      sticky     <= ST_CLEAN;
      status     <= 2'd0;
      done       <= (chunk_count == '0);
      flip_valid <= 1'b0;
    end else begin
      if (take) acc_cnt <= acc_cnt + CNT_W'(1);
      flip_valid <= active && s1_valid && (cls == ST_FIXED);
      if (s1_valid) begin
        flip_byte <= pos_abs;
        flip_bit  <= pos_bit;
      end
      if (active && s1_valid) sticky <= merged;
      done <= finish_now;
      if (finish_now) begin
        active <= 1'b0;
        status <= merged;
      end
    end
  end

  // A flip request only follows a syndrome of the correctable weight (R2, R3)
  assert_flip_weight_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flip_valid |-> ($past(s1_ones) == fix_target(run_page)));

  // Done is a single-cycle pulse unless a new run restarts it (R8)
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done || $past(start)));

  // Status only moves with done or a start (R6)
  assert_status_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(start)) |-> $stable(status));

  // Never more codes accepted than requested (R9)
  assert_accept_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_cnt <= total);
endmodule

// File: rtl/ecc_syndrome_checker.sv
module ecc_syndrome_checker
  import ecc_chk_pkg::*;
#(
  parameter int MAX_CHUNKS = 16
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        start,
  input  logic                                        page_mode,
  input  logic [$clog2(MAX_CHUNKS+1)-1:0]             chunk_count,
  input  logic                                        code_valid,
  input  logic [31:0]                                 stored_code,
  input  logic [31:0]                                 fresh_code,
  output logic                                        flip_valid,
  output logic [((MAX_CHUNKS > 1 ? $clog2(MAX_CHUNKS) : 1) + 8 > 12 ?
                 (MAX_CHUNKS > 1 ? $clog2(MAX_CHUNKS) : 1) + 8 : 12)-1:0] flip_byte,
  output logic [3:0]                                  flip_bit,
  output logic [1:0]                                  status,
  output logic                                        done
);
  localparam int CNT_W  = $clog2(MAX_CHUNKS + 1);
  localparam int IDX_W  = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1;
  localparam int ADDR_W = (IDX_W + CHUNK_LOG2 > PAGE_POS_W) ? IDX_W + CHUNK_LOG2 : PAGE_POS_W;

  logic              take;
  logic [IDX_W-1:0]  take_idx;
  logic              run_page;
  logic              active;
  logic              s1_valid;
  logic [CODE_W-1:0] s1_syn;
  logic [ONES_W-1:0] s1_ones;
  logic [IDX_W-1:0]  s1_idx;
  chk_status_e       cls;
  logic [ADDR_W-1:0] pos_abs;
  logic [BIT_W-1:0]  pos_bit;

  ecc_syn_stage #(.IDX_W(IDX_W)) u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (start),
    .take        (take),
    .page_mode   (run_page),
    .stored_code (stored_code),
    .fresh_code  (fresh_code),
    .idx_in      (take_idx),
    .s1_valid    (s1_valid),
    .s1_syn      (s1_syn),
    .s1_ones     (s1_ones),
    .s1_idx      (s1_idx)
  );

  ecc_classify #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_class (
    .page_mode (run_page),
    .s1_syn    (s1_syn),
    .s1_ones   (s1_ones),
    .s1_idx    (s1_idx),
    .cls       (cls),
    .pos_abs   (pos_abs),
    .pos_bit   (pos_bit)
  );

  ecc_seq #(.CNT_W(CNT_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .page_mode   (page_mode),
    .chunk_count (chunk_count),
    .code_valid  (code_valid),
    .s1_valid    (s1_valid),
    .s1_ones     (s1_ones),
    .s1_idx      (s1_idx),
    .cls         (cls),
    .pos_abs     (pos_abs),
    .pos_bit     (pos_bit),
    .take        (take),
    .take_idx    (take_idx),
    .run_page    (run_page),
    .active      (active),
    .flip_valid  (flip_valid),
    .flip_byte   (flip_byte),
    .flip_bit    (flip_bit),
    .status      (status),
    .done        (done)
  );

  // A chunk in the register stage always belongs to a live run (R7, R9)
  assert_stage_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> active);
endmodule

// File: tb/ecc_syndrome_checker_tb.sv
module ecc_syndrome_checker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        page_mode = 1'b0;
  logic [4:0]  chunk_count = '0;
  logic        code_valid = 1'b0;
  logic [31:0] stored_code = '0;
  logic [31:0] fresh_code = '0;
  logic        flip_valid;
  logic [11:0] flip_byte;
  logic [3:0]  flip_bit;
  logic [1:0]  status;
  logic        done;

  always #5 clk = ~clk;

  ecc_syndrome_checker #(.MAX_CHUNKS(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .page_mode(page_mode),
    .chunk_count(chunk_count), .code_valid(code_valid),
    .stored_code(stored_code), .fresh_code(fresh_code),
    .flip_valid(flip_valid), .flip_byte(flip_byte), .flip_bit(flip_bit),
    .status(status), .done(done)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int flip_n = 0;
  int done_n = 0;
  int done_cyc = 0;
  logic [11:0] last_byte = '0;
  logic [3:0]  last_bit = '0;
  logic [1:0]  done_st = '0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (flip_valid) begin
      flip_n++;
      last_byte = flip_byte;
      last_bit  = flip_bit;
    end
    if (done) begin
      done_n++;
      done_cyc = cyc;
      done_st  = status;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_start(input int cnt, input logic mode);
    start = 1'b1; chunk_count = 5'(cnt); page_mode = mode;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send(input logic [31:0] fresh, input logic [31:0] syn);
    code_valid = 1'b1; fresh_code = fresh; stored_code = fresh ^ syn;
    @(negedge clk);
    code_valid = 1'b0;
  endtask

  // {mode, fresh, syndrome, status, flip, byte, bit}
  localparam int NV = 12;
  localparam logic [83:0] VECS [NV] = '{
    {1'b0, 32'h12345678, 32'hA51F02D3, 2'd1, 1'b1, 12'h05A, 4'd3},
    {1'b0, 32'hDEADBEEF, 32'h000007FF, 2'd1, 1'b1, 12'h0FF, 4'd7},
    {1'b0, 32'h0F0F0F0F, 32'h003FF800, 2'd1, 1'b1, 12'h000, 4'd0},
    {1'b0, 32'hCAFEF00D, 32'h00000000, 2'd0, 1'b0, 12'h000, 4'd0},
    {1'b0, 32'h00000000, 32'h00010000, 2'd2, 1'b0, 12'h000, 4'd0},
    {1'b0, 32'h55AA55AA, 32'h80000004, 2'd2, 1'b0, 12'h000, 4'd0},
    {1'b0, 32'hFFFFFFFF, 32'h00000003, 2'd3, 1'b0, 12'h000, 4'd0},
    {1'b0, 32'h13579BDF, 32'h00000FFF, 2'd3, 1'b0, 12'h000, 4'd0},
    {1'b1, 32'h2468ACE0, 32'h003FABC5, 2'd1, 1'b1, 12'hABC, 4'd5},
    {1'b1, 32'h11111111, 32'h000007FF, 2'd3, 1'b0, 12'h000, 4'd0},
    {1'b1, 32'h89ABCDEF, 32'h07FF000F, 2'd1, 1'b1, 12'h000, 4'd15},
    {1'b1, 32'h76543210, 32'h40000000, 2'd2, 1'b0, 12'h000, 4'd0}
  };

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int f0, d0, k;
    repeat (3) @(negedge clk);
    chk("R10 flip_valid", int'(flip_valid), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 status", int'(status), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: one-chunk runs
    for (int v = 0; v < NV; v++) begin
      logic [83:0] e;
      string tag;
      e = VECS[v];
      if (e[19:18] == 2'd0)      tag = "R1";
      else if (e[19:18] == 2'd2) tag = "R4";
      else if (e[19:18] == 2'd3) tag = "R5";
      else if (e[83])            tag = "R3";
      else                       tag = "R2";
      f0 = flip_n; d0 = done_n;
      do_start(1, e[83]);
      k = cyc;
      send(e[82:51], e[50:19]);
      repeat (3) @(negedge clk);
      chk({tag, " status"}, int'(done_st), int'(e[18:17]));
      chk({tag, " done count"}, done_n - d0, 1);
      chk("R8 done timing", done_cyc, k + 2);
      chk({tag, " flip count"}, flip_n - f0, int'(e[16]));
      if (e[16]) begin
        chk({tag, " flip byte"}, int'(last_byte), int'(e[15:4]));
        chk({tag, " flip bit"}, int'(last_bit), int'(e[3:0]));
      end
    end

    // R6: sticky correction across clean chunks, with chunk offset (R2)
    f0 = flip_n; d0 = done_n;
    do_start(4, 1'b0);
    k = cyc;
    send(32'h1, 32'h0);
    send(32'h2, 32'h000007FF);
    send(32'h3, 32'h0);
    send(32'h4, 32'h0);
    repeat (3) @(negedge clk);
    chk("R6 sticky status", int'(done_st), 1);
    chk("R8 multi-chunk done timing", done_cyc, k + 5);
    chk("R2 offset flip count", flip_n - f0, 1);
    chk("R2 offset flip byte", int'(last_byte), 12'h1FF);
    chk("R6 status held", int'(status), 1);

    // R4 after a correction; R7 later chunk dropped
    f0 = flip_n; d0 = done_n;
    do_start(3, 1'b0);
    send(32'h5, 32'h000007FF);
    send(32'h6, 32'h00010000);
    send(32'h7, 32'h003FF800);
    repeat (4) @(negedge clk);
    chk("R4 abort status", int'(done_st), 2);
    chk("R7 flips after code abort", flip_n - f0, 1);
    chk("R7 single done", done_n - d0, 1);

    // R5 abort with trailing chunks back-to-back (R7)
    f0 = flip_n; d0 = done_n;
    do_start(4, 1'b0);
    send(32'h8, 32'h001F02D3);
    send(32'h9, 32'h00000003);
    send(32'hA, 32'h003FF800);
    send(32'hB, 32'h0);
    repeat (4) @(negedge clk);
    chk("R5 abort status", int'(done_st), 3);
    chk("R7 flips after multi abort", flip_n - f0, 1);
    chk("R7 flip byte chunk0", int'(last_byte), 12'h05A);
    chk("R7 single done", done_n - d0, 1);
    repeat (5) @(negedge clk);
    chk("R6 status held after abort", int'(status), 3);

    // R9: code_valid outside a run is ignored
    f0 = flip_n; d0 = done_n;
    send(32'hC, 32'h000007FF);
    repeat (3) @(negedge clk);
    chk("R9 idle flip", flip_n - f0, 0);
    chk("R9 idle done", done_n - d0, 0);
    chk("R9 idle status", int'(status), 3);

    // R9: empty run, restart clears status
    d0 = done_n;
    do_start(0, 1'b0);
    k = cyc;
    @(negedge clk);
    chk("R9 empty run done", done_n - d0, 1);
    chk("R9 empty run timing", done_cyc, k);
    chk("R9 empty run status", int'(done_st), 0);

    // R9: codes beyond chunk_count ignored
    f0 = flip_n; d0 = done_n;
    do_start(1, 1'b0);
    send(32'hD, 32'h000007FF);
    send(32'hE, 32'h003FF800);
    repeat (4) @(negedge clk);
    chk("R9 extra code flips", flip_n - f0, 1);
    chk("R9 extra code byte", int'(last_byte), 12'h0FF);
    chk("R9 extra code done", done_n - d0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule